// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block computes single-error-correcting Hamming parity over a page of 8-bit NAND data, one running result per chip select. Each byte on the data path arrives with the chip select it belongs to and its index inside a 512-byte window. Only chip selects whose NAND-mode enable bit is set take part. Column terms come from the data bits within each byte. Row terms come from the parity of whole bytes, sorted by the bits of the byte index.

Software or a sequencer starts a new page by pulsing the start input for one chip select. This clears that select's result. Bytes then stream in. At any time, the accumulated odd-parity terms of any select can be read from a fixed 32-bit result word. Error location and correction happen outside this block.

Top module: `nand_ecc_top`

## Requirements
- R1: After reset, the result of every chip select reads 32'h0000_0000.
- R2: Result layout: bit 16 is P1O, bit 17 is P2O, bit 18 is P4O, bits 19 to 27 are P8O to P2048O in ascending order, and all other bits read 0. A byte 8'h01 at index 0 on a cleared select gives 32'h0FFF_0000, and adding a byte 8'h80 at index 511 leaves it unchanged.
- R3: The column terms P1O, P2O and P4O are the XOR, over all accumulated bytes, of the data bits whose bit number has bit 0, 1 or 2 (respectively) equal to 0.
- R4: The row term for index bit k (k = 0 to 8; P8O to P2048O) is the XOR of the byte parity of every accumulated byte whose index has bit k equal to 0.
- R5: A byte for a chip select whose nandEnable bit is 0 leaves that select's result unchanged. Once the bit is set, bytes accumulate.
- R6: A start pulse for a chip select sets its result to zero on the next cycle and leaves the other selects' results unchanged.
- R7: If a start and a byte for the same select occur in one cycle, the clear wins and the byte is dropped. A byte for a different select in that cycle is still accumulated.
- R8: Only byteData[7:0] enters the parity. Bits 15 to 8 have no effect.
- R9: Each chip select keeps its own result. The word for readCs is presented combinationally and reflects every byte accepted at earlier clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| nandEnable | input | 4 | Per-select NAND-mode enable |
| startValid | input | 1 | Start (clear) strobe |
| startCs | input | 2 | Select cleared by the start strobe |
| byteValid | input | 1 | Data byte valid strobe |
| byteCs | input | 2 | Select the byte belongs to |
| byteData | input | 16 | Data bus; only the low byte is used |
| byteIdx | input | 9 | Byte index within the 512-byte window |
| readCs | input | 2 | Select whose result is shown |
| result | output | 32 | Packed odd-parity result word |

## Verification
A start pulse and a byte strobe can fall in the same cycle. The bench drives both together aimed at the same select, and expects that select to read zero afterwards. It then repeats the collision with the byte aimed at another select, and expects that select to show the byte folded in. Each outcome is checked against a bench-side parity model that applies the clear-before-accumulate rule, over interleaved random pages whose upper data byte is random.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  parameter int unsigned CS_NUM = 4;
  localparam int unsigned CS_W = $clog2(CS_NUM);
  localparam int unsigned COL_TERMS = 3;
  localparam int unsigned BYTE_W = 1 << COL_TERMS;

  typedef struct packed {
    logic [CS_NUM-1:0] clr;
    logic [CS_NUM-1:0] acc;
  } eccStrobe_t;
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic [CS_NUM-1:0] nandEnable,
  input  logic              startValid,
  input  logic [CS_W-1:0]   startCs,
  input  logic              byteValid,
  input  logic [CS_W-1:0]   byteCs,
  output eccStrobe_t        strb
);
  always_comb begin
    strb = '0;
    for (int i = 0; i < int'(CS_NUM); i++) begin
      strb.clr[i] = startValid && (startCs == CS_W'(i));
      strb.acc[i] = byteValid && (byteCs == CS_W'(i)) && nandEnable[i] && !strb.clr[i];
    end
  end
endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 9,
  localparam int unsigned TERMS = COL_TERMS + IDX_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  eccStrobe_t               strb,
  input  logic [DATA_W-1:0]        byteData,
  input  logic [IDX_W-1:0]         byteIdx,
  input  logic [CS_W-1:0]          readCs,
  output logic [TERMS-1:0]         readTerms,
  output logic [CS_NUM*TERMS-1:0]  accBus
);
  function automatic logic [BYTE_W-1:0] colMask(input int unsigned k);
    logic [BYTE_W-1:0] m;
    for (int unsigned b = 0; b < BYTE_W; b++) m[b] = ((b >> k) & 1) == 0;
    return m;
  endfunction

  logic [BYTE_W-1:0] lowByte;
  logic              bytePar;
  logic [TERMS-1:0]  contrib;
  logic [TERMS-1:0]  accQ [CS_NUM];

  always_comb begin
    lowByte = byteData[BYTE_W-1:0];
    bytePar = ^lowByte;
    for (int unsigned k = 0; k < COL_TERMS; k++)
      contrib[k] = ^(lowByte & colMask(k));
    for (int unsigned k = 0; k < IDX_W; k++)
      contrib[COL_TERMS + k] = bytePar & ~byteIdx[k];
  end

  for (genvar g = 0; g < int'(CS_NUM); g++) begin : gAcc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             accQ[g] <= '0;
      else if (strb.clr[g])  accQ[g] <= '0;
      else if (strb.acc[g])  accQ[g] <= accQ[g] ^ contrib;
    end
    assign accBus[g*TERMS +: TERMS] = accQ[g];

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      strb.clr[g] |=> accQ[g] == '0); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.clr[g] && !strb.acc[g]) |=> $stable(accQ[g])); // R9
  end

  assign readTerms = accQ[readCs];
endmodule

// File: rtl/nand_ecc_top.sv
module nand_ecc_top
  import nand_ecc_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned RES_W   = 32,
  parameter int unsigned TERM_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CS_NUM-1:0] nandEnable,
  input  logic              startValid,
  input  logic [CS_W-1:0]   startCs,
  input  logic              byteValid,
  input  logic [CS_W-1:0]   byteCs,
  input  logic [DATA_W-1:0] byteData,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [CS_W-1:0]   readCs,
  output logic [RES_W-1:0]  result
);
  localparam int unsigned TERMS = COL_TERMS + IDX_W;

  eccStrobe_t              strb;
  logic [TERMS-1:0]        readTerms;
  logic [CS_NUM*TERMS-1:0] accBus;

  nand_ecc_ctrl u_ctrl (
    .nandEnable (nandEnable),
    .startValid (startValid),
    .startCs    (startCs),
    .byteValid  (byteValid),
    .byteCs     (byteCs),
    .strb       (strb)
  );

  nand_ecc_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .byteData  (byteData),
    .byteIdx   (byteIdx),
    .readCs    (readCs),
    .readTerms (readTerms),
    .accBus    (accBus)
  );

  always_comb begin
    result = '0;
    result[TERM_LSB +: TERMS] = readTerms;
  end

  for (genvar g = 0; g < int'(CS_NUM); g++) begin : gChk
    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
      (byteValid && byteCs == CS_W'(g) && !nandEnable[g]
       && !(startValid && startCs == CS_W'(g)))
      |=> $stable(accBus[g*TERMS +: TERMS])); // R5
    AST_HIGH_BYTE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
      (byteValid && byteCs == CS_W'(g) && byteData[BYTE_W-1:0] == '0
       && !(startValid && startCs == CS_W'(g)))
      |=> $stable(accBus[g*TERMS +: TERMS])); // R8
    AST_COLLIDE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (startValid && startCs == CS_W'(g) && byteValid && byteCs == CS_W'(g))
      |=> accBus[g*TERMS +: TERMS] == '0); // R7
  end
endmodule

// File: tb/nand_ecc_top_test.sv
module nand_ecc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;

  typedef struct {
    int          cs;
    logic [31:0] exp;
    string       tag;
  } sbItem_t;

  logic        clk = 0;
  logic        rstN = 0;
  logic [3:0]  nandEnable = '0;
  logic        startValid = 0;
  logic [1:0]  startCs = '0;
  logic        byteValid = 0;
  logic [1:0]  byteCs = '0;
  logic [15:0] byteData = '0;
  logic [8:0]  byteIdx = '0;
  logic [1:0]  readCs = '0;
  logic [31:0] result;

  sbItem_t sb[$];
  int pushCnt = 0, popCnt = 0;
  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [31:0] model [NCS];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_ecc_top uut (
    .clk(clk), .rstN(rstN), .nandEnable(nandEnable),
    .startValid(startValid), .startCs(startCs),
    .byteValid(byteValid), .byteCs(byteCs),
    .byteData(byteData), .byteIdx(byteIdx),
    .readCs(readCs), .result(result)
  );

  // Reference contribution of one byte, laid out as in R2
  function automatic logic [31:0] refWord(input logic [7:0] d, input logic [8:0] idx);
    logic [31:0] w = '0;
    logic bp = 0;
    for (int b = 0; b < 8; b++) bp ^= d[b];
    for (int k = 0; k < 3; k++)
      for (int b = 0; b < 8; b++)
        if (((b >> k) & 1) == 0) w[16 + k] ^= d[b];
    for (int k = 0; k < 9; k++)
      if (!idx[k]) w[19 + k] = bp;
    return w;
  endfunction

  task automatic drive(input bit sv, input int scs, input bit bv, input int bcs,
                       input logic [15:0] d, input logic [8:0] idx);
    @(negedge clk);
    startValid = sv; startCs = 2'(scs);
    byteValid = bv; byteCs = 2'(bcs); byteData = d; byteIdx = idx;
    if (sv) model[scs] = '0;
    if (bv && nandEnable[bcs] && !(sv && scs == bcs))
      model[bcs] ^= refWord(d[7:0], idx);
  endtask

  task automatic sendByte(input int cs, input logic [15:0] d, input logic [8:0] idx);
    drive(0, 0, 1, cs, d, idx);
  endtask

  task automatic sendStart(input int cs);
    drive(1, cs, 0, 0, '0, '0);
  endtask

  task automatic sendPage(input int cs);
    for (int i = 0; i < 512; i++) sendByte(cs, 16'($urandom), 9'(i));
  endtask

  task automatic expectVal(input int cs, input logic [31:0] exp, input string tag);
    sbItem_t it;
    @(negedge clk);
    startValid = 0; byteValid = 0;
    it.cs = cs; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    pushCnt++;
    wait (popCnt == pushCnt);
  endtask

  task automatic expectModel(input int cs, input string tag);
    expectVal(cs, model[cs], tag);
  endtask

  // Monitor: pops expected items and compares against the result port
  initial begin
    sbItem_t it;
    forever begin
      wait (pushCnt != popCnt);
      it = sb.pop_front();
      #1 readCs = 2'(it.cs);
      #1;
      nChecks++;
      if (result !== it.exp) begin
        nFails++;
        $display("FAIL %s cs%0d: actual %h expected %h", it.tag, it.cs, result, it.exp);
      end
      popCnt++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    for (int i = 0; i < NCS; i++) expectVal(i, 32'h0, "R1");

    nandEnable = 4'b1011;
    // R2: directed layout
    sendByte(1, 16'h0001, 9'd0);
    expectVal(1, 32'h0FFF_0000, "R2");
    sendByte(1, 16'h0080, 9'd511);
    expectVal(1, 32'h0FFF_0000, "R2");

    // R3: random page on cs0
    sendPage(0);
    expectModel(0, "R3");
    // R4: directed row term, then random page on cs3
    sendByte(3, 16'h0003, 9'h155);
    expectModel(3, "R4");
    sendPage(3);
    expectModel(3, "R4");

    // R5: disabled select ignores bytes, then accumulates once enabled
    for (int i = 0; i < 40; i++) sendByte(2, 16'($urandom), 9'(i));
    expectVal(2, 32'h0, "R5");
    @(negedge clk) nandEnable = 4'b1111;
    sendPage(2);
    expectModel(2, "R5");

    // R6: clear one select, others kept
    sendStart(0);
    expectVal(0, 32'h0, "R6");
    expectModel(3, "R6");
    expectModel(1, "R6");

    // R7: collision on same select, then on different selects
    drive(1, 1, 1, 1, 16'h00FF, 9'd0);
    expectVal(1, 32'h0, "R7");
    drive(1, 1, 1, 3, 16'h0001, 9'd0);
    expectVal(1, 32'h0, "R7");
    expectModel(3, "R7");

    // R8: high byte has no effect
    sendStart(1);
    sendByte(1, 16'hA500, 9'd0);
    expectVal(1, 32'h0, "R8");
    sendByte(1, 16'hFF01, 9'd0);
    expectVal(1, 32'h0FFF_0000, "R8");

    // R9: interleaved selects over a fresh window
    for (int c = 0; c < NCS; c++) sendStart(c);
    for (int i = 0; i < 512; i++) sendByte(int'($urandom_range(0, 3)), 16'($urandom), 9'(i));
    for (int c = 0; c < NCS; c++) expectModel(c, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule